// File: doc/BRIEF.md
# Board Control Register Bank

This block is a bank of 32-bit registers in a 4 KB window on a plain memory bus: one address, a read strobe, a write strobe, write data and registered read data. It holds a user LED register, whose bits drive LED output pins, a general control word and an optional debug control word. Its button and optional switch registers read as zero. Two time counters tick once per second and once per hundredth of a second. Their rates come from the system clock frequency, given as a parameter.

Three offsets belong to a separate prescaled event counter. This block does not store them. It passes each access to them out as a read or write strobe with a small index and the write data. For a read, it returns the data the counter block supplies. The addresses of the other registers matter to software, so they are fixed. Any address that is not decoded reads as zero, and a write to it is lost.

Top module: `board_ctl_regs`

## Requirements
- R1: Only full-word aligned addresses are decoded. Any other address in the window, including an address with bits [1:0] not zero and the holes 0x0C, 0x24 and 0x2C to 0x48, reads as zero, and a write to it changes no register and raises no forwarding strobe.
- R2: A write to 0x00 stores bits [LED_COUNT-1:0] of the write data and drops the rest. Bit i of the stored value drives `led_o[i]`, active high, from the cycle after the write. A read of 0x00 returns the stored bits with zeros above them.
- R3: When HAS_DEBUG is 1, 0x04 stores a full 32-bit word and reads it back. When HAS_DEBUG is 0 it acts as a hole. Offset 0x28 (switches) reads as zero whether HAS_SWITCH is set or not, and writes to it are lost.
- R4: Offset 0x4C stores a full 32-bit word and reads it back unchanged.
- R5: Offset 0x08 (buttons) always reads as zero. A write to it has no effect.
- R6: The seconds counter at 0x10 increments by one every CLK_HZ clock cycles. After reset, its first increment takes place at the CLK_HZ-th rising edge.
- R7: The hundredths counter at 0x14 increments by one every CLK_HZ/100 clock cycles, with the same phase rule as R6.
- R8: A write to 0x10 or 0x14 loads that counter with the write data and restarts its divider. The counter next increments exactly one period (CLK_HZ or CLK_HZ/100 cycles) after the write edge.
- R9: Reset clears the LED, control and debug registers, both time counters and their dividers, the read data and the read-valid flag.
- R10: `bus_rvalid` is high in the cycle after each cycle with `bus_rd` high, and low otherwise. `bus_rdata` then holds the register value as it was before that edge. Between reads it keeps its last value.
- R11: An access to 0x18, 0x1C or 0x20 raises `fwd_rd` or `fwd_wr` in the same cycle, with `fwd_idx` set to 0, 1 or 2 in that order. A read at one of these offsets returns `fwd_rdata`, sampled at the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| led_o | output | LED_COUNT | LED drive, active high |
| fwd_rd | output | 1 | Read strobe to the event counter block |
| fwd_wr | output | 1 | Write strobe to the event counter block |
| fwd_idx | output | 2 | Selects the event counter register: 0 count, 1 reload, 2 prescaler |
| fwd_wdata | output | 32 | Write data to the event counter block |
| fwd_rdata | input | 32 | Read data from the event counter block |

## Verification
The hardest points to reach from the ports are the divider boundaries. Once a second and once a hundredth of a second, a read can land on the very edge where a counter steps, and a preset write can land part way through a divider period. The bench builds the design with CLK_HZ at 1000, so both boundaries come round within a few thousand cycles. It polls both counters on alternate cycles for longer than a full second. It then presets both counters at an arbitrary divider phase and keeps polling. The reference model checks each step edge, including the one that follows a preset.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;

  localparam logic [AW-1:0] OFF_LED    = 12'h000;
  localparam logic [AW-1:0] OFF_DEBUG  = 12'h004;
  localparam logic [AW-1:0] OFF_BUTTON = 12'h008;
  localparam logic [AW-1:0] OFF_SEC    = 12'h010;
  localparam logic [AW-1:0] OFF_CENTI  = 12'h014;
  localparam logic [AW-1:0] OFF_EVCNT  = 12'h018;
  localparam logic [AW-1:0] OFF_RELOAD = 12'h01C;
  localparam logic [AW-1:0] OFF_PSCNT  = 12'h020;
  localparam logic [AW-1:0] OFF_SWITCH = 12'h028;
  localparam logic [AW-1:0] OFF_CTRL   = 12'h04C;

  typedef enum logic [1:0] {
    FWD_COUNT  = 2'd0,
    FWD_RELOAD = 2'd1,
    FWD_PRESC  = 2'd2,
    FWD_NONE   = 2'd3
  } fwd_sel_e;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int unsigned DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (DIV < 2) ? 1 : $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase;

  assign tick = (phase == LAST) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (restart || phase == LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/time_counter.sv
module time_counter #(
  parameter int unsigned DIV = 10,
  parameter int unsigned W   = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] value
);
  logic step;

  tick_divider #(.DIV(DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load),
    .tick    (step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (load) begin
      value <= load_val;
    end else if (step) begin
      value <= value + 1'b1;
    end
  end
endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
  import board_ctl_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned LED_COUNT  = 2,
  parameter bit          HAS_DEBUG  = 1'b0,
  parameter bit          HAS_SWITCH = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_rvalid,
  output logic [LED_COUNT-1:0] led_o,
  output logic                 fwd_rd,
  output logic                 fwd_wr,
  output logic [1:0]           fwd_idx,
  output logic [31:0]          fwd_wdata,
  input  logic [31:0]          fwd_rdata
);
  localparam int unsigned SEC_DIV   = CLK_HZ;
  localparam int unsigned CENTI_DIV = CLK_HZ / 100;

  logic [LED_COUNT-1:0] led_q;
  logic [DW-1:0]        ctrl_q;
  logic [DW-1:0]        debug_q;
  logic [DW-1:0]        sec_val;
  logic [DW-1:0]        centi_val;
  logic                 sec_load;
  logic                 centi_load;
  logic                 switch_hit;
  fwd_sel_e             fwd_sel;
  logic [DW-1:0]        rd_mux;

  // Event counter forwarding decode
  always_comb begin
    unique case (bus_addr)
      OFF_EVCNT:  fwd_sel = FWD_COUNT;
      OFF_RELOAD: fwd_sel = FWD_RELOAD;
      OFF_PSCNT:  fwd_sel = FWD_PRESC;
      default:    fwd_sel = FWD_NONE;
    endcase
  end

  assign fwd_rd    = bus_rd && (fwd_sel != FWD_NONE);
  assign fwd_wr    = bus_wr && (fwd_sel != FWD_NONE);
  assign fwd_idx   = fwd_sel;
  assign fwd_wdata = bus_wdata;

  assign sec_load   = bus_wr && (bus_addr == OFF_SEC);
  assign centi_load = bus_wr && (bus_addr == OFF_CENTI);
  assign switch_hit = HAS_SWITCH && (bus_addr == OFF_SWITCH);

  time_counter #(.DIV(SEC_DIV), .W(DW)) u_sec (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sec_load),
    .load_val (bus_wdata),
    .value    (sec_val)
  );

  time_counter #(.DIV(CENTI_DIV), .W(DW)) u_centi (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (centi_load),
    .load_val (bus_wdata),
    .value    (centi_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q  <= '0;
      ctrl_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFF_LED)  led_q  <= bus_wdata[LED_COUNT-1:0];
      if (bus_addr == OFF_CTRL) ctrl_q <= bus_wdata;
    end
  end

  generate
    if (HAS_DEBUG) begin : g_debug
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          debug_q <= '0;
        end else if (bus_wr && bus_addr == OFF_DEBUG) begin
          debug_q <= bus_wdata;
        end
      end
    end else begin : g_no_debug
      assign debug_q = '0;
    end
  endgenerate

  assign led_o = led_q;

  always_comb begin
    rd_mux = '0;
    if (fwd_sel != FWD_NONE) begin
      rd_mux = fwd_rdata;
    end else if (switch_hit) begin
      rd_mux = '0;
    end else begin
      case (bus_addr)
        OFF_LED:    rd_mux = DW'(led_q);
        OFF_DEBUG:  rd_mux = debug_q;
        OFF_BUTTON: rd_mux = '0;
        OFF_SEC:    rd_mux = sec_val;
        OFF_CENTI:  rd_mux = centi_val;
        OFF_CTRL:   rd_mux = ctrl_q;
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/board_ctl_regs_chk.sv
module board_ctl_regs_chk #(
  parameter int unsigned LED_COUNT = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_rd,
  input logic                 bus_wr,
  input logic [11:0]          bus_addr,
  input logic [31:0]          bus_wdata,
  input logic                 bus_rvalid,
  input logic [LED_COUNT-1:0] led_o,
  input logic                 fwd_rd,
  input logic                 fwd_wr,
  input logic [1:0]           fwd_idx,
  input logic [31:0]          sec_val,
  input logic                 sec_load,
  input logic [31:0]          centi_val,
  input logic                 centi_load
);
  // R10
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  // R10
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  // R2
  led_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h000) |=> (led_o == $past(bus_wdata[LED_COUNT-1:0])));

  // R11
  fwd_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_rd || fwd_wr) |-> (fwd_idx != 2'd3));

  // R1
  misaligned_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] != 2'b00) |-> (!fwd_rd && !fwd_wr));

  // R6
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_load |=> (sec_val == $past(sec_val) || sec_val == $past(sec_val) + 32'd1));

  // R7
  centi_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !centi_load |=> (centi_val == $past(centi_val) || centi_val == $past(centi_val) + 32'd1));

  // R8
  sec_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_load |=> (sec_val == $past(bus_wdata)));

  // R8
  centi_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    centi_load |=> (centi_val == $past(bus_wdata)));
endmodule

bind board_ctl_regs board_ctl_regs_chk #(.LED_COUNT(LED_COUNT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .led_o      (led_o),
  .fwd_rd     (fwd_rd),
  .fwd_wr     (fwd_wr),
  .fwd_idx    (fwd_idx),
  .sec_val    (sec_val),
  .sec_load   (sec_load),
  .centi_val  (centi_val),
  .centi_load (centi_load)
);

// File: tb/board_ctl_regs_bench.sv
module board_ctl_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1000;
  localparam int LEDS       = 3;
  localparam int SEC_DIV    = CLK_HZ;
  localparam int CENTI_DIV  = CLK_HZ / 100;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [LEDS-1:0] led_o;
  logic        fwd_rd;
  logic        fwd_wr;
  logic [1:0]  fwd_idx;
  logic [31:0] fwd_wdata;
  logic [31:0] fwd_rdata;

  assign fwd_rdata = 32'hA5A5_0000 | 32'(fwd_idx);

  always #(CLK_PERIOD/2) clk = ~clk;

  board_ctl_regs #(
    .CLK_HZ(CLK_HZ), .LED_COUNT(LEDS), .HAS_DEBUG(1'b1), .HAS_SWITCH(1'b1)
  ) u_board_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .led_o(led_o), .fwd_rd(fwd_rd), .fwd_wr(fwd_wr),
    .fwd_idx(fwd_idx), .fwd_wdata(fwd_wdata), .fwd_rdata(fwd_rdata)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit preset_done = 0;

  // reference model state
  longint m_led = 0, m_ctrl = 0, m_dbg = 0, m_sec = 0, m_cs = 0;
  int     sec_ph = 0, cs_ph = 0;
  logic [31:0] m_rdata = '0;
  bit     m_rvalid = 0;
  string  m_tag = "R9";

  function automatic int fwd_of(input logic [11:0] a);
    case (a)
      12'h018: return 0;
      12'h01C: return 1;
      12'h020: return 2;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    if (fwd_of(a) >= 0) return 32'hA5A5_0000 | 32'(fwd_of(a));
    case (a)
      12'h000: return 32'(m_led);
      12'h004: return 32'(m_dbg);
      12'h010: return 32'(m_sec);
      12'h014: return 32'(m_cs);
      12'h04C: return 32'(m_ctrl);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    case (a)
      12'h000: return "R2";
      12'h004: return "R3";
      12'h028: return "R3";
      12'h008: return "R5";
      12'h04C: return "R4";
      12'h010: return preset_done ? "R8" : "R6";
      12'h014: return preset_done ? "R8" : "R7";
      12'h018, 12'h01C, 12'h020: return "R11";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_led = 0; m_ctrl = 0; m_dbg = 0; m_sec = 0; m_cs = 0;
      sec_ph = 0; cs_ph = 0; m_rdata = '0; m_rvalid = 0; m_tag = "R9";
    end else begin
      if (bus_rd) begin
        m_rdata = model_read(bus_addr);
        m_tag = tag_of(bus_addr);
      end
      m_rvalid = bus_rd;
      if (bus_wr && bus_addr == 12'h010) begin m_sec = bus_wdata; sec_ph = 0; end
      else if (sec_ph == SEC_DIV-1) begin sec_ph = 0; m_sec = (m_sec + 1) & 32'hFFFF_FFFF; end
      else sec_ph++;
      if (bus_wr && bus_addr == 12'h014) begin m_cs = bus_wdata; cs_ph = 0; end
      else if (cs_ph == CENTI_DIV-1) begin cs_ph = 0; m_cs = (m_cs + 1) & 32'hFFFF_FFFF; end
      else cs_ph++;
      if (bus_wr && bus_addr == 12'h000) m_led = bus_wdata & ((1 << LEDS) - 1);
      if (bus_wr && bus_addr == 12'h04C) m_ctrl = bus_wdata;
      if (bus_wr && bus_addr == 12'h004) m_dbg = bus_wdata;
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(rst_n ? m_tag : "R9", "rdata", bus_rdata, m_rdata);
      check(rst_n ? "R10" : "R9", "rvalid", bus_rvalid, m_rvalid);
      check(rst_n ? "R2" : "R9", "led_o", led_o, m_led);
      check("R11", "fwd_rd", fwd_rd, bus_rd && fwd_of(bus_addr) >= 0);
      check("R11", "fwd_wr", fwd_wr, bus_wr && fwd_of(bus_addr) >= 0);
      if (fwd_rd || fwd_wr) check("R11", "fwd_idx", fwd_idx, fwd_of(bus_addr));
      if (fwd_wr) check("R11", "fwd_wdata", fwd_wdata, bus_wdata);
    end
  end

  task automatic step();
    @(posedge clk); #1;
    bus_rd = 0; bus_wr = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
    step();
  endtask

  task automatic rd(input logic [11:0] a);
    bus_rd = 1; bus_wr = 0; bus_addr = a;
    step();
  endtask

  task automatic rdwr(input logic [11:0] a, input logic [31:0] d);
    bus_rd = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    wr(12'h000, 32'hFFFF_FFFF); rd(12'h000);
    wr(12'h000, 32'h0000_0005); rd(12'h000);
    wr(12'h04C, 32'hDEAD_BEEF); rd(12'h04C);
    wr(12'h004, 32'h1234_5678); rd(12'h004);
    wr(12'h008, 32'h0000_000F); rd(12'h008);
    wr(12'h028, 32'h0000_FFFF); rd(12'h028);
    wr(12'h00C, 32'h0000_0077); rd(12'h00C);
    wr(12'h04E, 32'h1111_1111); rd(12'h04E); rd(12'h04C);
    wr(12'h024, 32'h2222_2222); rd(12'h024); rd(12'h000);
    wr(12'h018, 32'h0000_0042); wr(12'h01C, 32'h9); wr(12'h020, 32'h3);
    rd(12'h018); rd(12'h01C); rd(12'h020); rd(12'h019);
    rdwr(12'h04C, 32'hCAFE_F00D); rd(12'h04C);
    for (int i = 0; i < 1300; i++) begin rd(12'h014); rd(12'h010); end
    wr(12'h010, 32'h0000_0100);
    repeat (3) step();
    wr(12'h014, 32'h0000_0050);
    preset_done = 1;
    for (int i = 0; i < 700; i++) begin rd(12'h014); rd(12'h010); end
    rd(12'h004);
    repeat (2) step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule